// File: doc/BRIEF.md
# DSP Memory Decoder with ROM Paging

This block sits between a signal processor and its memories. The processor has three memory selects: boot, program and data. It also has a read strobe, a write strobe, a 14-bit address bus and an 8-bit data path into this block. Every clock cycle carries one processor bus cycle. The block sorts that cycle into exactly one action:
- a command read,
- a ROM read,
- a program-side RAM access,
- a data-side RAM access,
- a write to a control register,
- or nothing.

The action appears as a registered enable one clock later.

The ROM space is 16 MB. A ROM read address is the 14-bit page register placed above the low 10 processor address bits. Because only eight data bits reach the block, the processor loads the page register in two separate writes: one for the low byte and one for the upper six bits. A third control write flips a board LED, which the processor firmware blinks about once a second. Boot fetches always use page zero, so start-up code is found whatever the page register holds.

The core is a small state machine. Its state is the class of the bus cycle captured at the last clock edge:
- `ST_IDLE`: no enable.
- `ST_CMD_RD`: command read enable.
- `ST_ROM_RD`: ROM read enable.
- `ST_RAM_PM`: program-side RAM enable.
- `ST_RAM_DM`: data-side RAM enable.
- `ST_CTL_WR`: control write enable.

On every edge the machine moves from any state to the state chosen by the classifier for the current bus cycle. When no select or strobe is active, that move is to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `dsp_mem_decoder`

## Requirements
- R1: At most one of `cmd_rd_en`, `rom_rd_en`, `ram_pm_en`, `ram_dm_en`, `ctl_wr_en` is high in any cycle. Each enable is registered and reflects the bus cycle sampled at the previous rising clock edge.
- R2: When more than one select is low, the boot select wins over the program select, and the program select wins over the data select.
- R3: A boot-select read (`boot_sel_n`=0, `rd_n`=0) raises `rom_rd_en`. In that case `rom_addr` = {14'b0, `dsp_addr[9:0]`}, whatever the page register holds.
- R4: A program-select read with `dsp_addr[13]`=1 raises `rom_rd_en`, with `rom_addr` = {page[13:0], `dsp_addr[9:0]`}. `rom_addr` keeps its last value in cycles that are not ROM reads.
- R5: A program-select read or write with `dsp_addr[13]`=0 raises `ram_pm_en`. A data-select read or write at an address below 14'h3FF0 raises `ram_dm_en`. `ram_wr_en` is high with either RAM enable exactly when the cycle was a write (`rd_n`=1, `wr_n`=0).
- R6: A data-select read at 14'h3FF0 raises `cmd_rd_en`.
- R7: A data-select write at 14'h3FF1 loads page[7:0] from `dsp_data[7:0]`. A write at 14'h3FF2 loads page[13:8] from `dsp_data[5:0]`. Each leaves the other half unchanged, raises `ctl_wr_en`, and takes effect for the next ROM read.
- R8: A data-select write at 14'h3FF3 inverts `led` and raises `ctl_wr_en`. The data value has no effect.
- R9: Reset drives all enables, `ram_wr_en`, `led`, the page register and `rom_addr` to zero.
- R10: The following raise no enable and change neither the page register nor `led`: program or boot writes to the ROM window, boot-select writes, data-select reads at 14'h3FF1 to 14'h3FF3, any data-select access at 14'h3FF4 to 14'h3FFF, a write at 14'h3FF0, and cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one processor bus cycle per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel_n | input | 1 | Boot memory select, active low |
| prog_sel_n | input | 1 | Program memory select, active low |
| data_sel_n | input | 1 | Data memory select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dsp_addr | input | 14 | Processor address bus |
| dsp_data | input | 8 | Processor write data (low 8 bits) |
| cmd_rd_en | output | 1 | Command read enable |
| rom_rd_en | output | 1 | ROM read enable |
| rom_addr | output | 24 | Paged ROM address |
| ram_pm_en | output | 1 | RAM enable, program side |
| ram_dm_en | output | 1 | RAM enable, data side |
| ram_wr_en | output | 1 | RAM write qualifier |
| ctl_wr_en | output | 1 | Control register write strobe |
| led | output | 1 | Board LED drive |

## Verification
The assertions assume the processor asserts at most one strobe per cycle. They also assume that every bus cycle is complete within one clock, with its address and data stable at the sampling edge. The bench drives every cycle at the falling edge and never lowers `rd_n` and `wr_n` together. It deliberately lowers several selects at once only in the cases that exercise the priority rule of R2.

// File: rtl/dspdec_pkg.sv
package dspdec_pkg;

    // Class of one processor bus cycle, also the decoder state
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD_RD = 3'd1,
        ST_ROM_RD = 3'd2,
        ST_RAM_PM = 3'd3,
        ST_RAM_DM = 3'd4,
        ST_CTL_WR = 3'd5
    } cyc_state_e;

    // Which control register a control write targets
    typedef enum logic [1:0] {
        CTL_NONE    = 2'd0,
        CTL_PAGE_LO = 2'd1,
        CTL_PAGE_HI = 2'd2,
        CTL_LED     = 2'd3
    } ctl_sel_e;

    typedef struct packed {
        cyc_state_e kind;
        ctl_sel_e   ctl;
        logic       is_wr;
        logic       boot;
    } cyc_class_t;

endpackage

// File: rtl/dspdec_classify.sv
module dspdec_classify
    import dspdec_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int CTL_WIN_W = 4,
    parameter logic [ADDR_W-1:0] CTL_BASE     = 14'h3FF0,
    parameter logic [ADDR_W-1:0] CMD_ADDR     = 14'h3FF0,
    parameter logic [ADDR_W-1:0] PAGE_LO_ADDR = 14'h3FF1,
    parameter logic [ADDR_W-1:0] PAGE_HI_ADDR = 14'h3FF2,
    parameter logic [ADDR_W-1:0] LED_ADDR     = 14'h3FF3
) (
    input  logic              boot_sel_n,
    input  logic              prog_sel_n,
    input  logic              data_sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output cyc_class_t        cls
);
    localparam int WIN_HI = ADDR_W - 1;

    logic is_rd;
    logic is_wr;
    logic active;
    logic rom_win;
    logic in_ctl_win;

    always_comb begin
        is_rd      = !rd_n;
        is_wr      = rd_n && !wr_n;
        active     = is_rd || is_wr;
        rom_win    = addr[WIN_HI];
        in_ctl_win = (addr[WIN_HI:CTL_WIN_W] == CTL_BASE[WIN_HI:CTL_WIN_W]);
    end

    // Priority: boot select, then program select, then data select
    always_comb begin
        cls       = '0;
        cls.kind  = ST_IDLE;
        cls.ctl   = CTL_NONE;
        cls.is_wr = is_wr;
        if (!boot_sel_n) begin
            if (is_rd) begin
                cls.kind = ST_ROM_RD;
                cls.boot = 1'b1;
            end
        end else if (!prog_sel_n) begin
            if (rom_win) begin
                if (is_rd) cls.kind = ST_ROM_RD;
            end else if (active) begin
                cls.kind = ST_RAM_PM;
            end
        end else if (!data_sel_n) begin
            if (in_ctl_win) begin
                if (is_rd && addr == CMD_ADDR) begin
                    cls.kind = ST_CMD_RD;
                end else if (is_wr && addr == PAGE_LO_ADDR) begin
                    cls.kind = ST_CTL_WR;
                    cls.ctl  = CTL_PAGE_LO;
                end else if (is_wr && addr == PAGE_HI_ADDR) begin
                    cls.kind = ST_CTL_WR;
                    cls.ctl  = CTL_PAGE_HI;
                end else if (is_wr && addr == LED_ADDR) begin
                    cls.kind = ST_CTL_WR;
                    cls.ctl  = CTL_LED;
                end
            end else if (active) begin
                cls.kind = ST_RAM_DM;
            end
        end
    end

endmodule

// File: rtl/dspdec_ctl_regs.sv
module dspdec_ctl_regs
    import dspdec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_class_t        cls,
    input  logic [DATA_W-1:0] data,
    output logic [PAGE_W-1:0] page,
    output logic              led
);
    localparam int HI_W = PAGE_W - DATA_W;

    logic ctl_hit;
    assign ctl_hit = (cls.kind == ST_CTL_WR);

    logic [DATA_W-1:0] page_lo;
    logic [HI_W-1:0]   page_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_lo <= '0;
        end else if (ctl_hit && cls.ctl == CTL_PAGE_LO) begin
            page_lo <= data;
        end
    end

    generate
        if (HI_W > 0) begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    page_hi <= '0;
                end else if (ctl_hit && cls.ctl == CTL_PAGE_HI) begin
                    page_hi <= data[HI_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led <= 1'b0;
        end else if (ctl_hit && cls.ctl == CTL_LED) begin
            led <= !led;
        end
    end

    assign page = {page_hi, page_lo};

endmodule

// File: rtl/dspdec_fsm.sv
module dspdec_fsm
    import dspdec_pkg::*;
#(
    parameter int LOW_W  = 10,
    parameter int PAGE_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cyc_class_t              cls,
    input  logic [LOW_W-1:0]        addr_lo,
    input  logic [PAGE_W-1:0]       page,
    output logic                    cmd_rd_en,
    output logic                    rom_rd_en,
    output logic [PAGE_W+LOW_W-1:0] rom_addr,
    output logic                    ram_pm_en,
    output logic                    ram_dm_en,
    output logic                    ram_wr_en,
    output logic                    ctl_wr_en
);
    localparam int ROM_W = PAGE_W + LOW_W;

    cyc_state_e        state;
    logic              wr_q;
    logic [ROM_W-1:0]  rom_addr_q;

    // State register: every edge moves to the class of the current cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= cls.kind;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_addr_q <= '0;
            wr_q       <= 1'b0;
        end else begin
            if (cls.kind == ST_ROM_RD) begin
                rom_addr_q <= {(cls.boot ? {PAGE_W{1'b0}} : page), addr_lo};
            end
            wr_q <= cls.is_wr &&
                    (cls.kind == ST_RAM_PM || cls.kind == ST_RAM_DM);
        end
    end

    // Output process
    always_comb begin
        cmd_rd_en = 1'b0;
        rom_rd_en = 1'b0;
        ram_pm_en = 1'b0;
        ram_dm_en = 1'b0;
        ram_wr_en = 1'b0;
        ctl_wr_en = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_CMD_RD: cmd_rd_en = 1'b1;
            ST_ROM_RD: rom_rd_en = 1'b1;
            ST_RAM_PM: begin
                ram_pm_en = 1'b1;
                ram_wr_en = wr_q;
            end
            ST_RAM_DM: begin
                ram_dm_en = 1'b1;
                ram_wr_en = wr_q;
            end
            ST_CTL_WR: ctl_wr_en = 1'b1;
            default:   ;
        endcase
    end

    assign rom_addr = rom_addr_q;

endmodule

// File: rtl/dsp_mem_decoder.sv
module dsp_mem_decoder
    import dspdec_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 8,
    parameter int LOW_W     = 10,
    parameter int PAGE_W    = 14,
    parameter int CTL_WIN_W = 4,
    parameter logic [ADDR_W-1:0] CTL_BASE     = 14'h3FF0,
    parameter logic [ADDR_W-1:0] CMD_ADDR     = 14'h3FF0,
    parameter logic [ADDR_W-1:0] PAGE_LO_ADDR = 14'h3FF1,
    parameter logic [ADDR_W-1:0] PAGE_HI_ADDR = 14'h3FF2,
    parameter logic [ADDR_W-1:0] LED_ADDR     = 14'h3FF3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    boot_sel_n,
    input  logic                    prog_sel_n,
    input  logic                    data_sel_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       dsp_addr,
    input  logic [DATA_W-1:0]       dsp_data,
    output logic                    cmd_rd_en,
    output logic                    rom_rd_en,
    output logic [PAGE_W+LOW_W-1:0] rom_addr,
    output logic                    ram_pm_en,
    output logic                    ram_dm_en,
    output logic                    ram_wr_en,
    output logic                    ctl_wr_en,
    output logic                    led
);
    cyc_class_t        cls;
    logic [PAGE_W-1:0] page;

    dspdec_classify #(
        .ADDR_W       (ADDR_W),
        .CTL_WIN_W    (CTL_WIN_W),
        .CTL_BASE     (CTL_BASE),
        .CMD_ADDR     (CMD_ADDR),
        .PAGE_LO_ADDR (PAGE_LO_ADDR),
        .PAGE_HI_ADDR (PAGE_HI_ADDR),
        .LED_ADDR     (LED_ADDR)
    ) u_classify (
        .boot_sel_n (boot_sel_n),
        .prog_sel_n (prog_sel_n),
        .data_sel_n (data_sel_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (dsp_addr),
        .cls        (cls)
    );

    dspdec_ctl_regs #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .data  (dsp_data),
        .page  (page),
        .led   (led)
    );

    dspdec_fsm #(
        .LOW_W  (LOW_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .addr_lo   (dsp_addr[LOW_W-1:0]),
        .page      (page),
        .cmd_rd_en (cmd_rd_en),
        .rom_rd_en (rom_rd_en),
        .rom_addr  (rom_addr),
        .ram_pm_en (ram_pm_en),
        .ram_dm_en (ram_dm_en),
        .ram_wr_en (ram_wr_en),
        .ctl_wr_en (ctl_wr_en)
    );

endmodule

// File: rtl/dspdec_checker.sv
module dspdec_checker #(
    parameter int ADDR_W = 14,
    parameter int LOW_W  = 10,
    parameter int PAGE_W = 14,
    parameter logic [ADDR_W-1:0] LED_ADDR = 14'h3FF3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    boot_sel_n,
    input logic                    prog_sel_n,
    input logic                    data_sel_n,
    input logic                    rd_n,
    input logic                    wr_n,
    input logic [ADDR_W-1:0]       dsp_addr,
    input logic                    cmd_rd_en,
    input logic                    rom_rd_en,
    input logic [PAGE_W+LOW_W-1:0] rom_addr,
    input logic                    ram_pm_en,
    input logic                    ram_dm_en,
    input logic                    ram_wr_en,
    input logic                    ctl_wr_en,
    input logic                    led
);
    localparam int ROM_W = PAGE_W + LOW_W;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rd_en, rom_rd_en, ram_pm_en, ram_dm_en, ctl_wr_en})); // R1

    AST_BOOT_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_sel_n && !rd_n) |=>
            (rom_rd_en && rom_addr[ROM_W-1:LOW_W] == '0)); // R3

    AST_BOOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_sel_n && !rd_n && (!prog_sel_n || !data_sel_n)) |=>
            (rom_rd_en && !ram_pm_en && !ram_dm_en && !cmd_rd_en)); // R2

    AST_PROG_ROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel_n && !prog_sel_n && !rd_n && dsp_addr[ADDR_W-1]) |=>
            (rom_rd_en && rom_addr[LOW_W-1:0] == $past(dsp_addr[LOW_W-1:0]))); // R4

    AST_LED_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel_n && prog_sel_n && !data_sel_n && rd_n && !wr_n &&
         dsp_addr == LED_ADDR) |=> (ctl_wr_en && led != $past(led))); // R8

    AST_RAM_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (ram_pm_en || ram_dm_en)); // R5

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |=>
            !(cmd_rd_en || rom_rd_en || ram_pm_en || ram_dm_en || ctl_wr_en)); // R10

endmodule

bind dsp_mem_decoder dspdec_checker #(
    .ADDR_W   (ADDR_W),
    .LOW_W    (LOW_W),
    .PAGE_W   (PAGE_W),
    .LED_ADDR (LED_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_sel_n (boot_sel_n),
    .prog_sel_n (prog_sel_n),
    .data_sel_n (data_sel_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .dsp_addr   (dsp_addr),
    .cmd_rd_en  (cmd_rd_en),
    .rom_rd_en  (rom_rd_en),
    .rom_addr   (rom_addr),
    .ram_pm_en  (ram_pm_en),
    .ram_dm_en  (ram_dm_en),
    .ram_wr_en  (ram_wr_en),
    .ctl_wr_en  (ctl_wr_en),
    .led        (led)
);

// File: tb/dsp_mem_decoder_tb.sv
module dsp_mem_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel_n = 1'b1;
    logic        prog_sel_n = 1'b1;
    logic        data_sel_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [13:0] dsp_addr = '0;
    logic [7:0]  dsp_data = '0;
    logic        cmd_rd_en, rom_rd_en, ram_pm_en, ram_dm_en, ram_wr_en;
    logic        ctl_wr_en, led;
    logic [23:0] rom_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    dsp_mem_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_sel_n (boot_sel_n),
        .prog_sel_n (prog_sel_n),
        .data_sel_n (data_sel_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .dsp_addr   (dsp_addr),
        .dsp_data   (dsp_data),
        .cmd_rd_en  (cmd_rd_en),
        .rom_rd_en  (rom_rd_en),
        .rom_addr   (rom_addr),
        .ram_pm_en  (ram_pm_en),
        .ram_dm_en  (ram_dm_en),
        .ram_wr_en  (ram_wr_en),
        .ctl_wr_en  (ctl_wr_en),
        .led        (led)
    );

    // Expected result of one bus cycle; en = {cmd, rom, ram_pm, ram_dm, ctl}
    typedef struct {
        logic [4:0]  en;
        logic        wr;
        logic [23:0] addr;
        logic        led;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Bench reference state
    logic [13:0] m_page = '0;
    logic        m_led  = 1'b0;
    logic [23:0] m_rom  = '0;

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Driver: one bus cycle, expected outcome pushed to the scoreboard
    task automatic cyc(input logic b, input logic p, input logic d,
                       input logic r, input logic w, input logic [13:0] a,
                       input logic [7:0] dt, input string tag);
        exp_t e;
        logic rd, wr;
        @(negedge clk);
        boot_sel_n = b; prog_sel_n = p; data_sel_n = d;
        rd_n = r; wr_n = w; dsp_addr = a; dsp_data = dt;
        rd = !r;
        wr = r && !w;
        e.en = 5'b0; e.wr = 1'b0; e.tag = tag;
        if (!b) begin
            if (rd) begin
                e.en = 5'b01000;
                m_rom = {14'd0, a[9:0]};
            end
        end else if (!p) begin
            if (a >= 14'h2000) begin
                if (rd) begin
                    e.en = 5'b01000;
                    m_rom = {m_page, a[9:0]};
                end
            end else if (rd || wr) begin
                e.en = 5'b00100;
                e.wr = wr;
            end
        end else if (!d) begin
            if (a < 14'h3FF0) begin
                if (rd || wr) begin
                    e.en = 5'b00010;
                    e.wr = wr;
                end
            end else if (rd && a == 14'h3FF0) begin
                e.en = 5'b10000;
            end else if (wr && a == 14'h3FF1) begin
                e.en = 5'b00001;
                m_page[7:0] = dt;
            end else if (wr && a == 14'h3FF2) begin
                e.en = 5'b00001;
                m_page[13:8] = dt[5:0];
            end else if (wr && a == 14'h3FF3) begin
                e.en = 5'b00001;
                m_led = !m_led;
            end
        end
        e.addr = m_rom;
        e.led  = m_led;
        exp_q.push_back(e);
    endtask

    // Monitor: compares outputs just after the edge that registered the cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " enables"},
                      {27'd0, cmd_rd_en, rom_rd_en, ram_pm_en, ram_dm_en, ctl_wr_en},
                      {27'd0, e.en});
                check({e.tag, " ram_wr"}, {31'd0, ram_wr_en}, {31'd0, e.wr});
                check({e.tag, " rom_addr"}, {8'd0, rom_addr}, {8'd0, e.addr});
                check({e.tag, " led"}, {31'd0, led}, {31'd0, e.led});
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9 reset enables",
              {27'd0, cmd_rd_en, rom_rd_en, ram_pm_en, ram_dm_en, ctl_wr_en}, 32'd0);
        check("R9 reset rom_addr/led/wr", {7'd0, rom_addr, led}, 32'd0);
        check("R9 reset ram_wr", {31'd0, ram_wr_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: boot reads at page zero
        cyc(0, 1, 1, 0, 1, 14'h0155, 8'h00, "R3 boot read");
        cyc(0, 1, 1, 0, 1, 14'h03FF, 8'h00, "R3 boot read top");
        // R4: program ROM read, page zero
        cyc(1, 0, 1, 0, 1, 14'h2123, 8'h00, "R4 prog rom page0");
        // R10: idle cycle keeps rom_addr
        cyc(1, 1, 1, 1, 1, 14'h0000, 8'h00, "R10 idle");
        // R7: page low byte then read
        cyc(1, 1, 0, 1, 0, 14'h3FF1, 8'hA5, "R7 page lo write");
        cyc(1, 0, 1, 0, 1, 14'h3C01, 8'h00, "R7 R4 read after lo");
        // R7: page high bits (upper two data bits dropped)
        cyc(1, 1, 0, 1, 0, 14'h3FF2, 8'hFF, "R7 page hi write");
        cyc(1, 0, 1, 0, 1, 14'h2200, 8'h00, "R7 R4 read after hi");
        // R7: low rewrite leaves high half
        cyc(1, 1, 0, 1, 0, 14'h3FF1, 8'h3C, "R7 lo keeps hi");
        cyc(1, 0, 1, 0, 1, 14'h23FF, 8'h00, "R7 R4 read page 3F3C");
        // R3: boot still uses page zero with nonzero page
        cyc(0, 1, 1, 0, 1, 14'h0012, 8'h00, "R3 boot ignores page");
        // R5: RAM accesses
        cyc(1, 0, 1, 0, 1, 14'h1FFF, 8'h00, "R5 pm ram read");
        cyc(1, 0, 1, 1, 0, 14'h0000, 8'h00, "R5 pm ram write");
        cyc(1, 1, 0, 0, 1, 14'h3FEF, 8'h00, "R5 dm ram read edge");
        cyc(1, 1, 0, 1, 0, 14'h0100, 8'h00, "R5 dm ram write");
        // R6: command read
        cyc(1, 1, 0, 0, 1, 14'h3FF0, 8'h00, "R6 cmd read");
        // R8: LED toggles, data irrelevant
        cyc(1, 1, 0, 1, 0, 14'h3FF3, 8'h00, "R8 led on");
        cyc(1, 1, 0, 1, 0, 14'h3FF3, 8'h00, "R8 led off");
        cyc(1, 1, 0, 1, 0, 14'h3FF3, 8'hFF, "R8 led on again");
        // R10: ignored cycles
        cyc(1, 0, 1, 1, 0, 14'h3000, 8'h00, "R10 prog rom write");
        cyc(0, 1, 1, 1, 0, 14'h0010, 8'h00, "R10 boot write");
        cyc(1, 1, 0, 0, 1, 14'h3FF1, 8'h00, "R10 page lo read");
        cyc(1, 1, 0, 1, 0, 14'h3FF4, 8'h77, "R10 unused ctl write");
        cyc(1, 1, 0, 0, 1, 14'h3FFF, 8'h00, "R10 unused ctl read");
        cyc(1, 1, 0, 1, 0, 14'h3FF0, 8'h55, "R10 cmd write");
        cyc(1, 0, 1, 0, 1, 14'h2001, 8'h00, "R10 page unchanged read");
        // R2: select priority
        cyc(0, 0, 0, 0, 1, 14'h0044, 8'h00, "R2 boot over all");
        cyc(1, 0, 0, 0, 1, 14'h3FF0, 8'h00, "R2 prog over data");
        cyc(1, 0, 0, 1, 0, 14'h3FF3, 8'h00, "R2 prog blocks led");
        // R1: back-to-back distinct classes
        cyc(1, 1, 0, 0, 1, 14'h3FF0, 8'h00, "R1 cmd");
        cyc(1, 0, 1, 0, 1, 14'h2002, 8'h00, "R1 rom");
        cyc(1, 1, 1, 1, 1, 14'h0000, 8'h00, "R1 idle tail");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule